// File: doc/BRIEF.md
# Constant On-Time Boost Gate Timer

This block drives the gate of the boost switch in a power factor stage that runs at the edge of continuous conduction. It needs no inductor current sensing. The gate is held high for a computed number of clock cycles. The gate then stays low until a zero-crossing pulse arrives from the inductor's auxiliary winding, and the next on-pulse starts. The on-time comes from a digitised bus voltage sample compared with a fixed reference. That error is integrated, and the integral plus a proportional term sets the on-time. The gain of both terms depends on the operating phase of the lamp controller: a fast start-up phase, an ignition phase and a steady run phase.

Two adjustments shape the on-time. It is clamped between programmable minimum and maximum counts. A programmable extra count is added while the rectified line level is below a near-zero threshold, which fills in the line current around the line zero crossings.

A watchdog restarts the gate if no zero-crossing pulse arrives, so the converter cannot stall. The on-time is captured when the gate rises, so a pulse in progress is never altered by a new sample.

The controller is a three-state machine:
- **IDLE**: gate low. It is entered at reset or whenever `enable` is low.
- **ON**: gate high. The machine moves IDLE→ON on enable.
- **OFF**: gate low, waiting.
  - ON→OFF happens when the captured count expires.
  - OFF→ON happens on a zero-crossing or on watchdog expiry.
  - ON→IDLE and OFF→IDLE happen when `enable` drops.

Top module: `pfc_ontime_gate`

## Requirements
- R1: While reset is asserted, or one cycle after `enable` is seen low, `gate` and `cycle_done` are low. Disabling clears the stored error and the accumulator to zero, so the first pulse after re-enabling has the clamped on-time of a zero error.
- R2: Each `sample_valid` cycle while enabled stores err = BUS_REF − `bus_sample` and adds (err << KI) to the accumulator. The requested on-time is accumulator + (stored err << KP), in clock cycles.
- R3: The gain is chosen by `mode`, as (KP, KI) shifts:
  - 2'b00 start-up: (2, 1).
  - 2'b01 ignition: (3, 2).
  - 2'b10 run: (0, 0).
  - 2'b11: behaves as run.
- R4: The requested on-time is clamped to at most `ton_max` and at least max(`ton_min`, 1). The lower bound wins if the two conflict.
- R5: When `line_level` < `phase_thresh` (strictly less), `zc_extra` is added after the clamp. Otherwise nothing is added.
- R6: The on-time is captured on the cycle the gate rises. Samples arriving during a pulse do not change that pulse's width.
- R7: After the on-time ends, the gate stays low until `zc_pulse` is seen high at a clock edge. The gate is then high from the next cycle. A `zc_pulse` seen while the gate is high has no effect.
- R8: If no `zc_pulse` arrives, the gate restarts after exactly WD_CYCLES low cycles.
- R9: `cycle_done` is high for exactly the first cycle of every on-pulse that follows an OFF interval (zero-crossing or watchdog). It is not asserted for the first pulse after enabling.
- R10: The accumulator saturates symmetrically at ±(2^(ACC_W−1) − 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the converter; low forces IDLE and clears the integrator |
| mode | input | 2 | Gain phase: 00 start-up, 01 ignition, 10/11 run |
| bus_sample | input | VW | Digitised bus voltage |
| sample_valid | input | 1 | One-cycle strobe qualifying `bus_sample` |
| line_level | input | VW | Rectified line magnitude |
| phase_thresh | input | VW | Near-zero threshold for on-time extension |
| ton_min | input | CW | Minimum on-time in cycles |
| ton_max | input | CW | Maximum on-time in cycles |
| zc_extra | input | CW | Extra cycles added near line zero |
| zc_pulse | input | 1 | Inductor current zero-crossing indication |
| gate | output | 1 | Boost switch gate drive |
| cycle_done | output | 1 | Strobe at the start of each restarted pulse |

## Verification
The bench goes after the following corner cases:
- **Saturation.** The accumulator is driven into positive saturation and then unwound. A design that wrapped or did not saturate would produce a wrong width after recovery.
- **Conflicting clamp bounds.** A zero `ton_min` must yield a one-cycle pulse, not a zero-length or runaway one.
- **Threshold boundary.** A line level equal to the threshold must add nothing, catching an off-by-one comparison.
- **Mid-pulse stimulus.** Zero-crossing pulses and new samples are injected in the middle of a pulse. A design without on-time capture, or one that reacts to zero-crossings while high, would show a changed width or a spurious restart.
- **Watchdog and strobe.** The watchdog low time is measured to the cycle. `cycle_done` is counted per pulse to catch stretched, missing or extra strobes.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ON   = 2'b01,
        ST_OFF  = 2'b10
    } gate_state_e;

    typedef enum logic [1:0] {
        GM_START  = 2'b00,
        GM_IGNITE = 2'b01,
        GM_RUN    = 2'b10,
        GM_SPARE  = 2'b11
    } gain_mode_e;
endpackage

// File: rtl/pfc_err_integrator.sv
module pfc_err_integrator
    import pfc_pkg::*;
#(
    parameter int VW       = 10,
    parameter int ACC_W    = 16,
    parameter int MAX_SH   = 4,
    parameter int BUS_REF  = 512,
    parameter int KP_START = 2,
    parameter int KI_START = 1,
    parameter int KP_IGN   = 3,
    parameter int KI_IGN   = 2,
    parameter int KP_RUN   = 0,
    parameter int KI_RUN   = 0,
    localparam int EW      = VW + 1,
    localparam int PW      = EW + MAX_SH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    sample_valid,
    input  logic [VW-1:0]           bus_sample,
    input  logic [1:0]              mode,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [PW-1:0]    prop
);
    localparam int XW = ((ACC_W > PW) ? ACC_W : PW) + 1;
    localparam logic signed [XW-1:0] POS_LIM = XW'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [XW-1:0] NEG_LIM = -POS_LIM;

    logic [2:0]              kp_sh;
    logic [2:0]              ki_sh;
    logic signed [EW-1:0]    err_now;
    logic signed [EW-1:0]    err_q;
    logic signed [XW-1:0]    inc_base;
    logic signed [XW-1:0]    inc_x;
    logic signed [XW-1:0]    acc_x;
    logic signed [XW-1:0]    sum_x;
    logic signed [ACC_W-1:0] acc_nx;
    logic signed [PW-1:0]    prop_base;

    // Gain selection per operating phase
    always_comb begin
        unique case (gain_mode_e'(mode))
            GM_START:  begin kp_sh = 3'(KP_START); ki_sh = 3'(KI_START); end
            GM_IGNITE: begin kp_sh = 3'(KP_IGN);   ki_sh = 3'(KI_IGN);   end
            GM_RUN:    begin kp_sh = 3'(KP_RUN);   ki_sh = 3'(KI_RUN);   end
            default:   begin kp_sh = 3'(KP_RUN);   ki_sh = 3'(KI_RUN);   end
        endcase
    end

    // Error, integral step and saturation
    always_comb begin
        err_now  = $signed(EW'(BUS_REF)) - $signed({1'b0, bus_sample});
        inc_base = {{(XW-EW){err_now[EW-1]}}, err_now};
        inc_x    = inc_base <<< ki_sh;
        acc_x    = {{(XW-ACC_W){acc_q[ACC_W-1]}}, acc_q};
        sum_x    = acc_x + inc_x;
        if (sum_x > POS_LIM)
            acc_nx = POS_LIM[ACC_W-1:0];
        else if (sum_x < NEG_LIM)
            acc_nx = NEG_LIM[ACC_W-1:0];
        else
            acc_nx = sum_x[ACC_W-1:0];
    end

    // Proportional term from the stored error
    always_comb begin
        prop_base = {{(PW-EW){err_q[EW-1]}}, err_q};
        prop      = prop_base <<< kp_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
            acc_q <= '0;
        end else if (!enable) begin
            err_q <= '0;
            acc_q <= '0;
        end else if (sample_valid) begin
            err_q <= err_now;
            acc_q <= acc_nx;
        end
    end
endmodule

// File: rtl/pfc_ontime_calc.sv
module pfc_ontime_calc #(
    parameter int ACC_W = 16,
    parameter int PW    = 15,
    parameter int CW    = 12,
    parameter int VW    = 10
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic signed [PW-1:0]    prop,
    input  logic [CW-1:0]           ton_min,
    input  logic [CW-1:0]           ton_max,
    input  logic [CW-1:0]           zc_extra,
    input  logic [VW-1:0]           line_level,
    input  logic [VW-1:0]           phase_thresh,
    output logic [CW:0]             ton_req
);
    localparam int SW = ((ACC_W > PW) ? ACC_W : PW) + 2;

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lo_s;
    logic signed [SW-1:0] hi_s;
    logic [CW-1:0]        lo;
    logic [CW-1:0]        clip;
    logic                 near_zero;

    always_comb begin
        sum  = {{(SW-ACC_W){acc[ACC_W-1]}}, acc} + {{(SW-PW){prop[PW-1]}}, prop};
        lo   = (ton_min == '0) ? CW'(1) : ton_min;
        lo_s = $signed({{(SW-CW){1'b0}}, lo});
        hi_s = $signed({{(SW-CW){1'b0}}, ton_max});
        if (sum > hi_s)
            clip = ton_max;
        else if (sum < lo_s)
            clip = lo;
        else
            clip = sum[CW-1:0];
        if (clip < lo)
            clip = lo;
        near_zero = (line_level < phase_thresh);
        ton_req   = {1'b0, clip} + (near_zero ? {1'b0, zc_extra} : '0);
    end
endmodule

// File: rtl/pfc_gate_fsm.sv
module pfc_gate_fsm
    import pfc_pkg::*;
#(
    parameter int CW        = 12,
    parameter int WD_CYCLES = 2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        zc_pulse,
    input  logic [CW:0] ton_req,
    output logic        gate,
    output logic        cycle_done,
    output logic        in_idle,
    output logic [CW:0] ton_lat
);
    localparam int WDW = $clog2(WD_CYCLES + 1);
    localparam logic [WDW-1:0] WD_LAST = WDW'(WD_CYCLES - 1);

    gate_state_e    state, state_n;
    logic [CW:0]    on_cnt;
    logic [WDW-1:0] wd_cnt;
    logic           on_done;
    logic           wd_done;

    assign on_done = (on_cnt == ton_lat - (CW+1)'(1));
    assign wd_done = (wd_cnt == WD_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (enable) state_n = ST_ON;
            ST_ON: begin
                if (!enable)      state_n = ST_IDLE;
                else if (on_done) state_n = ST_OFF;
            end
            ST_OFF: begin
                if (!enable)                  state_n = ST_IDLE;
                else if (zc_pulse || wd_done) state_n = ST_ON;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // On-time capture and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ton_lat <= '0;
            on_cnt  <= '0;
            wd_cnt  <= '0;
        end else begin
            if (state_n == ST_ON && state != ST_ON) begin
                ton_lat <= ton_req;
                on_cnt  <= '0;
            end else if (state == ST_ON) begin
                on_cnt <= on_cnt + (CW+1)'(1);
            end
            if (state_n == ST_OFF && state != ST_OFF)
                wd_cnt <= '0;
            else if (state == ST_OFF)
                wd_cnt <= wd_cnt + WDW'(1);
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cycle_done <= 1'b0;
        else        cycle_done <= (state == ST_OFF) && (state_n == ST_ON);
    end

    always_comb begin
        gate    = (state == ST_ON);
        in_idle = (state == ST_IDLE);
    end
endmodule

// File: rtl/pfc_ontime_gate.sv
module pfc_ontime_gate #(
    parameter int VW        = 10,
    parameter int CW        = 12,
    parameter int ACC_W     = 16,
    parameter int MAX_SH    = 4,
    parameter int BUS_REF   = 512,
    parameter int KP_START  = 2,
    parameter int KI_START  = 1,
    parameter int KP_IGN    = 3,
    parameter int KI_IGN    = 2,
    parameter int KP_RUN    = 0,
    parameter int KI_RUN    = 0,
    parameter int WD_CYCLES = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [1:0]    mode,
    input  logic [VW-1:0] bus_sample,
    input  logic          sample_valid,
    input  logic [VW-1:0] line_level,
    input  logic [VW-1:0] phase_thresh,
    input  logic [CW-1:0] ton_min,
    input  logic [CW-1:0] ton_max,
    input  logic [CW-1:0] zc_extra,
    input  logic          zc_pulse,
    output logic          gate,
    output logic          cycle_done
);
    localparam int PW = VW + 1 + MAX_SH;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [PW-1:0]    prop;
    logic [CW:0]             ton_req;
    logic [CW:0]             ton_lat;
    logic                    in_idle;

    pfc_err_integrator #(
        .VW(VW), .ACC_W(ACC_W), .MAX_SH(MAX_SH), .BUS_REF(BUS_REF),
        .KP_START(KP_START), .KI_START(KI_START),
        .KP_IGN(KP_IGN), .KI_IGN(KI_IGN),
        .KP_RUN(KP_RUN), .KI_RUN(KI_RUN)
    ) u_integ (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .sample_valid(sample_valid), .bus_sample(bus_sample),
        .mode(mode), .acc_q(acc_q), .prop(prop)
    );

    pfc_ontime_calc #(.ACC_W(ACC_W), .PW(PW), .CW(CW), .VW(VW)) u_calc (
        .acc(acc_q), .prop(prop), .ton_min(ton_min), .ton_max(ton_max),
        .zc_extra(zc_extra), .line_level(line_level),
        .phase_thresh(phase_thresh), .ton_req(ton_req)
    );

    pfc_gate_fsm #(.CW(CW), .WD_CYCLES(WD_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .zc_pulse(zc_pulse),
        .ton_req(ton_req), .gate(gate), .cycle_done(cycle_done),
        .in_idle(in_idle), .ton_lat(ton_lat)
    );
endmodule

// File: rtl/pfc_ontime_chk.sv
module pfc_ontime_chk #(
    parameter int CW        = 12,
    parameter int WD_CYCLES = 2000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic        gate,
    input logic        cycle_done,
    input logic        in_idle,
    input logic [CW:0] ton_lat
);
    int unsigned low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                low_run <= 0;
        else if (gate || in_idle)  low_run <= 0;
        else                       low_run <= low_run + 1;
    end

    p_disabled_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !gate);

    p_ton_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (ton_lat != '0));

    p_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && $past(gate)) |-> $stable(ton_lat));

    p_rise_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (cycle_done || $past(in_idle)));

    p_wd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= WD_CYCLES);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    p_done_on_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> gate);
endmodule

bind pfc_ontime_gate pfc_ontime_chk #(.CW(CW), .WD_CYCLES(WD_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .gate(gate),
    .cycle_done(cycle_done), .in_idle(in_idle), .ton_lat(ton_lat)
);

// File: tb/pfc_ontime_gate_bench.sv
module pfc_ontime_gate_bench;
    localparam int VW = 10, CW = 12, ACC_W = 12, WD = 300, REF = 512;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0, enable = 1'b0, sample_valid = 1'b0, zc_pulse = 1'b0;
    logic [1:0]    mode = 2'b10;
    logic [VW-1:0] bus_sample = '0, line_level = '0, phase_thresh = '0;
    logic [CW-1:0] ton_min = 12'd20, ton_max = 12'd1000, zc_extra = '0;
    logic          gate, cycle_done;

    pfc_ontime_gate #(.VW(VW), .CW(CW), .ACC_W(ACC_W), .BUS_REF(REF), .WD_CYCLES(WD)) u_pfc_ontime_gate (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .bus_sample(bus_sample), .sample_valid(sample_valid),
        .line_level(line_level), .phase_thresh(phase_thresh),
        .ton_min(ton_min), .ton_max(ton_max), .zc_extra(zc_extra),
        .zc_pulse(zc_pulse), .gate(gate), .cycle_done(cycle_done)
    );

    int n_checks = 0, n_fail = 0;
    int m_acc = 0, m_err = 0;
    int mid_zc = -1, mid_s = -1, mid_val = 0;
    int lo_w, hi_w, dn_w;

    task automatic chk(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int kp_of(input logic [1:0] m);
        case (m) 2'b00: return 2; 2'b01: return 3; default: return 0; endcase
    endfunction
    function automatic int ki_of(input logic [1:0] m);
        case (m) 2'b00: return 1; 2'b01: return 2; default: return 0; endcase
    endfunction

    function automatic void m_apply(input int s);
        int lim;
        lim   = (1 << (ACC_W - 1)) - 1;
        m_err = REF - s;
        m_acc = m_acc + m_err * (1 << ki_of(mode));
        if (m_acc > lim)  m_acc = lim;
        if (m_acc < -lim) m_acc = -lim;
    endfunction

    function automatic int m_ton();
        int v, lo;
        v  = m_acc + m_err * (1 << kp_of(mode));
        lo = (ton_min == 0) ? 1 : int'(ton_min);
        if (v > int'(ton_max)) v = int'(ton_max);
        if (v < lo) v = lo;
        if (line_level < phase_thresh) v = v + int'(zc_extra);
        return v;
    endfunction

    // All tasks start and end at a falling edge
    task automatic measure(output int lo, output int hi, output int dn);
        lo = 0;
        while (gate !== 1'b1 && lo < 6000) begin lo++; @(negedge clk); end
        hi = 0; dn = 0;
        while (gate === 1'b1 && hi < 6000) begin
            zc_pulse     = (hi == mid_zc);
            sample_valid = (hi == mid_s);
            if (hi == mid_s) bus_sample = VW'(mid_val);
            dn += int'(cycle_done);
            hi++;
            @(negedge clk);
        end
        zc_pulse = 1'b0; sample_valid = 1'b0; mid_zc = -1; mid_s = -1;
    endtask

    task automatic apply(input int s);
        sample_valid = 1'b1; bus_sample = VW'(s);
        @(negedge clk);
        sample_valid = 1'b0;
        m_apply(s);
    endtask

    task automatic zc_then_measure(output int hi, output int dn);
        int lo;
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
        measure(lo, hi, dn);
    endtask

    task automatic restart(input logic [1:0] m);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 gate low after disable", int'(gate), 0);
        @(negedge clk);
        m_acc = 0; m_err = 0; mode = m;
        enable = 1'b1;
        measure(lo_w, hi_w, dn_w);
        chk("R1 first pulse after enable", hi_w, m_ton());
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 gate in reset", int'(gate), 0);
        chk("R1 done in reset", int'(cycle_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle gate low", int'(gate), 0);
    endtask

    task automatic t_first_pulse();
        enable = 1'b1;
        measure(lo_w, hi_w, dn_w);
        chk("R4 first pulse = ton_min", hi_w, 20);
        chk("R9 no done on first pulse", dn_w, 0);
    endtask

    task automatic t_track();
        apply(412);
        zc_then_measure(hi_w, dn_w);
        chk("R2 width from error", hi_w, 200);
        chk("R9 one done strobe after zc", dn_w, 1);
    endtask

    task automatic t_zc_ignored();
        int highs;
        mid_zc = 5;
        zc_then_measure(hi_w, dn_w);
        chk("R7 zc during pulse ignored", hi_w, m_ton());
        highs = 0;
        repeat (20) begin highs += int'(gate); @(negedge clk); end
        chk("R7 gate stays low without zc", highs, 0);
    endtask

    task automatic t_latch();
        int exp_w;
        exp_w = m_ton();
        mid_s = 10; mid_val = 312;
        zc_then_measure(hi_w, dn_w);
        chk("R6 width unchanged by mid sample", hi_w, exp_w);
        m_apply(312);
        zc_then_measure(hi_w, dn_w);
        chk("R6 new sample used on next pulse", hi_w, m_ton());
    endtask

    task automatic t_watchdog();
        measure(lo_w, hi_w, dn_w);
        chk("R8 watchdog low time", lo_w, WD);
        chk("R9 done on watchdog restart", dn_w, 1);
        chk("R8 width after restart", hi_w, m_ton());
    endtask

    task automatic t_gain_modes();
        for (int k = 0; k < 3; k++) begin
            logic [1:0] m;
            m = (k == 0) ? 2'b01 : (k == 1) ? 2'b00 : 2'b11;
            restart(m);
            apply(462);
            zc_then_measure(hi_w, dn_w);
            chk($sformatf("R3 gain mode %0d", m), hi_w, (k == 0) ? 600 : (k == 1) ? 300 : 100);
        end
    endtask

    task automatic t_clamp();
        restart(2'b10);
        apply(1000);
        zc_then_measure(hi_w, dn_w);
        chk("R4 negative error clamps low", hi_w, 20);
        ton_min = '0;
        zc_then_measure(hi_w, dn_w);
        chk("R4 zero minimum gives one cycle", hi_w, 1);
        ton_min = 12'd20; ton_max = 12'd250;
        apply(0);
        zc_then_measure(hi_w, dn_w);
        chk("R4 upper clamp", hi_w, 250);
    endtask

    task automatic t_modulation();
        zc_extra = 12'd37; phase_thresh = 10'd100;
        line_level = 10'd50;
        zc_then_measure(hi_w, dn_w);
        chk("R5 extra near zero", hi_w, 287);
        line_level = 10'd100;
        zc_then_measure(hi_w, dn_w);
        chk("R5 equal threshold adds nothing", hi_w, 250);
        line_level = 10'd99;
        zc_then_measure(hi_w, dn_w);
        chk("R5 just below threshold", hi_w, m_ton());
        zc_extra = '0; phase_thresh = '0; line_level = '0;
    endtask

    task automatic t_saturation();
        ton_max = 12'd3000;
        restart(2'b01);
        apply(0);
        zc_then_measure(hi_w, dn_w);
        chk("R10 saturated clamps high", hi_w, 3000);
        apply(0);
        mode = 2'b10;
        apply(1023);
        zc_then_measure(hi_w, dn_w);
        chk("R10 recovery from saturation", hi_w, 1025);
    endtask

    task automatic t_disable_mid();
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 gate high before disable", int'(gate), 1);
        enable = 1'b0;
        @(negedge clk);
        chk("R1 disable ends pulse", int'(gate), 0);
        repeat (3) @(negedge clk);
        chk("R1 stays low while disabled", int'(gate) + int'(cycle_done), 0);
    endtask

    initial begin
        t_reset();
        t_first_pulse();
        t_track();
        t_zc_ignored();
        t_latch();
        t_watchdog();
        t_gain_modes();
        t_clamp();
        t_modulation();
        t_saturation();
        t_disable_mid();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule